// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break, Error and Overrun Capture

This block receives asynchronous serial characters on a single input line. The line is sampled at sixteen times the bit rate through a one-cycle clock-enable pulse. Each character is written into a small first-in first-out store together with its own three status bits: break, framing error, and parity result. A reader pops entries through a show-ahead read port. The status outputs always describe the entry at the head of the store.

A frame state machine handles each character. The states are `S_IDLE`, `S_START`, `S_DATA`, `S_PAR`, `S_STOP` and `S_BRKW`, with these transitions:

- `S_IDLE` moves to `S_START` on a tick that sees the line low.
- `S_START` returns to `S_IDLE` when the mid-bit sample is high, which marks a glitch. When that sample is low it moves to `S_DATA`.
- `S_DATA` moves to `S_PAR` after the last data bit if a parity bit is configured. Otherwise it moves to `S_STOP`.
- `S_PAR` moves to `S_STOP` after one bit time.
- `S_STOP` moves to `S_BRKW` when the character is a break. Otherwise it moves to `S_IDLE`.
- `S_BRKW` moves to `S_IDLE` once the line has been high for half a bit time without interruption.

A reset-receiver command sends any state to `S_IDLE`.

A completed character first lands in a one-character waiting slot, which models the shift register, and moves into the store when there is room. When a new character completes while the store is full and the slot is occupied, the waiting character is replaced and a sticky overrun flag is raised. Only a reset-error-status command clears that flag.

Top module: `uart_rx_core`

## Requirements
- R1: A start bit is accepted only when the line is still low at the eighth tick after the low level is first seen. A high level there returns the receiver to idle and stores nothing.
- R2: Eight data bits are taken least significant bit first, each at the middle of its bit time. The completed character appears on `rd_data_o` with `rx_ready_o` high.
- R3: The stop bit is sampled at the middle of the first stop position. A low sample sets the framing bit (`rd_fe_o`) of that character, and a high sample leaves it clear.
- R4: `par_mode_i` selects the parity handling: 2'b00 means checked parity (`par_odd_i`=0 even, 1 odd), 2'b01 means forced parity equal to `par_odd_i`, and 2'b10 means no parity bit. `rd_pe_o` is 1 when the received parity bit differs from the expected one, and always 0 with 2'b10.
- R5: With `par_mode_i`=2'b11 (multidrop), a parity-position bit is still received, and `rd_pe_o` carries its value (the address/data flag) instead of a check result.
- R6: A character whose data bits and any parity bit are all zero and whose stop sample is low is stored once, with `rd_brk_o`=1, `rd_fe_o`=1 and data 0. Nothing more is stored until the line has been high for 8 consecutive ticks.
- R7: When a break begins in the middle of a character, that character is stored with `rd_fe_o`=1 and `rd_brk_o`=0. The break itself is reported as a second entry only if the line stays low to the end of the following character time.
- R8: The store holds 4 entries and the waiting slot holds one more character. When a character completes with both full, the waiting character is replaced by the new one, the stored entries are kept unchanged, and `overrun_o` is set. `fifo_full_o` reports a full store.
- R9: `overrun_o` stays set until `cmd_err_clr_i` is pulsed. `cmd_rx_reset_i` does not clear it.
- R10: While the store is empty, `rx_ready_o`, `rd_data_o`, `rd_brk_o`, `rd_fe_o` and `rd_pe_o` are all 0.
- R11: `cmd_rx_reset_i` empties the store and the waiting slot and returns the receiver to idle. The next character is then received normally.
- R12: After reset, the store is empty, `fifo_full_o` is 0 and `overrun_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Oversample enable, 16 pulses per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| par_mode_i | input | 2 | Parity handling: 00 checked, 01 forced, 10 none, 11 multidrop |
| par_odd_i | input | 1 | Odd parity select, or the forced parity value |
| cmd_err_clr_i | input | 1 | Pulse: clear the overrun flag |
| cmd_rx_reset_i | input | 1 | Pulse: empty the store and slot, return to idle |
| rd_en_i | input | 1 | Pop the head entry |
| rd_data_o | output | 8 | Head character data |
| rd_brk_o | output | 1 | Head character is a break |
| rd_fe_o | output | 1 | Head character had a framing error |
| rd_pe_o | output | 1 | Head parity error, or address/data flag in multidrop |
| rx_ready_o | output | 1 | Store is not empty |
| fifo_full_o | output | 1 | Store holds 4 entries |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
Several properties are checked on every cycle:

- A glitch at the start sample returns the machine to idle.
- A break entry always carries a framing error and zero data.
- The machine stays in the break-wait state until the line goes high.
- A full store keeps its head while nothing is popped.
- The overrun flag persists until it is cleared.
- The reset-receiver command empties the store.

Only the bench scenarios can show the rest:

- Bit order and sampling position across many data values.
- The expected parity outcome under each parity mode.
- That the break-wait window drops nothing legitimate after rearming.
- That a break starting mid-character yields exactly two entries.
- Which character survives an overrun.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
    parameter int unsigned RX_DATA_W = 8;

    typedef enum logic [1:0] {
        PAR_CHECK = 2'b00,
        PAR_FORCE = 2'b01,
        PAR_NONE  = 2'b10,
        PAR_ADDR  = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRKW
    } rx_state_e;

    typedef struct packed {
        logic                 brk;
        logic                 fe;
        logic                 pe;
        logic [RX_DATA_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/uart_rx_frame.sv
`timescale 1ns/1ps
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rxd_i,
    input  logic [1:0] par_mode_i,
    input  logic       par_odd_i,
    input  logic       clr_i,
    output logic       done_o,
    output rx_entry_t  frame_o
);
    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned IDX_W = $clog2(RX_DATA_W);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(RX_DATA_W - 1);

    rx_state_e            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [RX_DATA_W-1:0] shr_q;
    logic                 par_q;
    par_mode_e            mode;
    logic                 has_par, mid_hit, bit_hit, is_break, pe_calc;

    assign mode     = par_mode_e'(par_mode_i);
    assign has_par  = (mode != PAR_NONE);
    assign mid_hit  = tick_i && (cnt_q == HALF_LAST);
    assign bit_hit  = tick_i && (cnt_q == BIT_LAST);
    assign is_break = (shr_q == '0) && !(has_par && par_q) && !rxd_i;

    always_comb begin
        unique case (mode)
            PAR_CHECK: pe_calc = par_q ^ (^shr_q) ^ par_odd_i;
            PAR_FORCE: pe_calc = par_q ^ par_odd_i;
            PAR_NONE:  pe_calc = 1'b0;
            PAR_ADDR:  pe_calc = par_q;
            default:   pe_calc = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:  if (tick_i && !rxd_i) state_d = S_START;
                S_START: if (mid_hit) state_d = rxd_i ? S_IDLE : S_DATA;
                S_DATA:  if (bit_hit && idx_q == IDX_LAST)
                             state_d = has_par ? S_PAR : S_STOP;
                S_PAR:   if (bit_hit) state_d = S_STOP;
                S_STOP:  if (bit_hit) state_d = is_break ? S_BRKW : S_IDLE;
                S_BRKW:  if (mid_hit && rxd_i) state_d = S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // Tick counter, bit index and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            shr_q <= '0;
            par_q <= 1'b0;
        end else if (clr_i || state_q == S_IDLE) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (tick_i) begin
            unique case (state_q)
                S_START: cnt_q <= mid_hit ? '0 : cnt_q + 1'b1;
                S_BRKW:  cnt_q <= rxd_i ? cnt_q + 1'b1 : '0;
                default: cnt_q <= (cnt_q == BIT_LAST) ? '0 : cnt_q + 1'b1;
            endcase
            if (state_q == S_DATA && cnt_q == BIT_LAST) begin
                shr_q <= {rxd_i, shr_q[RX_DATA_W-1:1]};
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == S_PAR && cnt_q == BIT_LAST) par_q <= rxd_i;
        end
    end

    // Outputs: completed character and its status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            frame_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (!clr_i && state_q == S_STOP && bit_hit) begin
                done_o       <= 1'b1;
                frame_o.data <= shr_q;
                frame_o.fe   <= !rxd_i;
                frame_o.brk  <= is_break;
                frame_o.pe   <= pe_calc;
            end
        end
    end

    assert_start_glitch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_START && mid_hit && rxd_i && !clr_i) |=> (state_q == S_IDLE && !done_o));

    assert_break_has_fe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && frame_o.brk) |-> (frame_o.fe && frame_o.data == '0));

    assert_break_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BRKW && !clr_i && !(tick_i && rxd_i)) |=> (state_q == S_BRKW));
endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_i,
    input  logic      wr_en_i,
    input  rx_entry_t wr_ent_i,
    input  logic      rd_en_i,
    output rx_entry_t rd_ent_o,
    output logic      empty_o,
    output logic      full_o
);
    localparam int unsigned AW = $clog2(DEPTH);

    rx_entry_t     mem_q [DEPTH];
    logic [AW:0]   wp_q, rp_q;
    logic          wr_ok, rd_ok;

    assign empty_o  = (wp_q == rp_q);
    assign full_o   = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    assign wr_ok    = wr_en_i && !full_o;
    assign rd_ok    = rd_en_i && !empty_o;
    assign rd_ent_o = mem_q[rp_q[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else if (clr_i) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (wr_ok) wp_q <= wp_q + 1'b1;
            if (rd_ok) rp_q <= rp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok && !clr_i) mem_q[wp_q[AW-1:0]] <= wr_ent_i;
    end

    assert_full_keeps_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !rd_en_i && !clr_i) |=> (full_o && rd_ent_o == $past(rd_ent_o)));

    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> empty_o);
endmodule

// File: rtl/uart_rx_core.sv
`timescale 1ns/1ps
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR        = 16,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16_i,
    input  logic                 rxd_i,
    input  logic [1:0]           par_mode_i,
    input  logic                 par_odd_i,
    input  logic                 cmd_err_clr_i,
    input  logic                 cmd_rx_reset_i,
    input  logic                 rd_en_i,
    output logic [RX_DATA_W-1:0] rd_data_o,
    output logic                 rd_brk_o,
    output logic                 rd_fe_o,
    output logic                 rd_pe_o,
    output logic                 rx_ready_o,
    output logic                 fifo_full_o,
    output logic                 overrun_o
);
    logic      rxd_meta_q, rxd_sync_q;
    logic      frm_done;
    rx_entry_t frm_ent;
    rx_entry_t hold_q, head;
    logic      hold_vld_q;
    logic      push, ovr_evt, empty, full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_meta_q <= 1'b1;
            rxd_sync_q <= 1'b1;
        end else begin
            rxd_meta_q <= rxd_i;
            rxd_sync_q <= rxd_meta_q;
        end
    end

    uart_rx_frame #(.OSR(OSR)) frame_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick16_i),
        .rxd_i      (rxd_sync_q),
        .par_mode_i (par_mode_i),
        .par_odd_i  (par_odd_i),
        .clr_i      (cmd_rx_reset_i),
        .done_o     (frm_done),
        .frame_o    (frm_ent)
    );

    assign push    = hold_vld_q && !full;
    assign ovr_evt = frm_done && hold_vld_q && full;

    // Waiting slot between the frame machine and the store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            hold_vld_q <= 1'b0;
        end else if (cmd_rx_reset_i) begin
            hold_vld_q <= 1'b0;
        end else if (frm_done) begin
            hold_q     <= frm_ent;
            hold_vld_q <= 1'b1;
        end else if (push) begin
            hold_vld_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             overrun_o <= 1'b0;
        else if (ovr_evt)       overrun_o <= 1'b1;
        else if (cmd_err_clr_i) overrun_o <= 1'b0;
    end

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cmd_rx_reset_i),
        .wr_en_i  (push),
        .wr_ent_i (hold_q),
        .rd_en_i  (rd_en_i),
        .rd_ent_o (head),
        .empty_o  (empty),
        .full_o   (full)
    );

    assign rx_ready_o  = !empty;
    assign fifo_full_o = full;
    assign rd_data_o   = empty ? '0 : head.data;
    assign rd_brk_o    = !empty && head.brk;
    assign rd_fe_o     = !empty && head.fe;
    assign rd_pe_o     = !empty && head.pe;

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !cmd_err_clr_i) |=> overrun_o);

    assert_overrun_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err_clr_i && !ovr_evt) |=> !overrun_o);

    assert_rx_reset_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rx_reset_i |=> (!rx_ready_o && !hold_vld_q));
endmodule

// File: tb/uart_rx_core_tb_top.sv
`timescale 1ns/1ps
module uart_rx_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, tick, rxd, par_odd, err_clr, rx_rst, rd_en;
    logic [1:0] par_mode;
    logic [7:0] rd_data;
    logic       rd_brk, rd_fe, rd_pe, rx_ready, fifo_full, overrun;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick16_i(tick), .rxd_i(rxd),
        .par_mode_i(par_mode), .par_odd_i(par_odd),
        .cmd_err_clr_i(err_clr), .cmd_rx_reset_i(rx_rst), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .rd_brk_o(rd_brk), .rd_fe_o(rd_fe), .rd_pe_o(rd_pe),
        .rx_ready_o(rx_ready), .fifo_full_o(fifo_full), .overrun_o(overrun)
    );

    initial begin
        tick = 1'b0;
        forever @(negedge clk) tick = ~tick;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        rxd = v;
        wait_ticks(16);
    endtask

    // start, 8 data bits LSB first, optional parity bit, one stop bit
    task automatic send_char(input logic [7:0] d, input bit use_par, input logic pbit, input logic stopv);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (use_par) send_bit(pbit);
        send_bit(stopv);
    endtask

    // returns {brk, fe, pe, data}
    task automatic read_entry(output logic [10:0] e);
        int w = 0;
        while (!rx_ready && w < 400) begin
            @(negedge clk);
            w++;
        end
        if (!rx_ready) begin
            e = 11'h7FF;
        end else begin
            e = {rd_brk, rd_fe, rd_pe, rd_data};
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic pulse(input int which);
        if (which == 0) err_clr = 1'b1; else rx_rst = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        rx_rst  = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [10:0] e;
        rst_n = 1'b0; rxd = 1'b1; par_mode = 2'b10; par_odd = 1'b0;
        err_clr = 1'b0; rx_rst = 1'b0; rd_en = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R12 / R10: reset state
        chk("R12 ready", rx_ready, 0);
        chk("R12 full", fifo_full, 0);
        chk("R12 overrun", overrun, 0);
        chk("R10 empty outputs", {rd_brk, rd_fe, rd_pe, rd_data}, 0);

        // R1: short low pulse is a glitch
        rxd = 1'b0; wait_ticks(4);
        rxd = 1'b1; wait_ticks(40);
        chk("R1 glitch stores nothing", rx_ready, 0);

        // R2: no-parity sweep
        for (int i = 0; i < 32; i++) begin
            logic [7:0] d;
            d = 8'(i * 37 + 5);
            send_char(d, 1'b0, 1'b0, 1'b1);
            rxd = 1'b1; wait_ticks(4);
            read_entry(e);
            chk("R2 data", e, {3'b000, d});
        end

        // R4 / R5: parity mode sweep
        for (int m = 0; m < 5; m++) begin
            logic [1:0] md;
            logic       od;
            md = (m < 2) ? 2'b00 : (m < 4) ? 2'b01 : 2'b11;
            od = m[0];
            par_mode = md; par_odd = od;
            for (int i = 0; i < 20; i++) begin
                logic [7:0] d;
                logic ideal, pbit, pe_exp;
                d = 8'(i * 53 + 11);
                ideal = (md == 2'b00) ? ((^d) ^ od) : od;
                if (md == 2'b11) begin
                    pbit = i[0];
                    pe_exp = pbit;
                end else begin
                    pbit = (i % 3 == 0) ? ~ideal : ideal;
                    pe_exp = (pbit != ideal);
                end
                send_char(d, 1'b1, pbit, 1'b1);
                rxd = 1'b1; wait_ticks(4);
                read_entry(e);
                chk((md == 2'b11) ? "R5 address bit" : "R4 parity", e, {2'b00, pe_exp, d});
            end
        end
        par_mode = 2'b10; par_odd = 1'b0;

        // R3: framing error
        send_char(8'h5A, 1'b0, 1'b0, 1'b0);
        rxd = 1'b1; wait_ticks(30);
        read_entry(e);
        chk("R3 framing", e, {3'b010, 8'h5A});
        chk("R10 ready after drain", rx_ready, 0);
        chk("R10 status zero", {rd_brk, rd_fe, rd_pe, rd_data}, 0);

        // R6: break, blocked window, rearm
        send_char(8'h00, 1'b0, 1'b0, 1'b0);
        rxd = 1'b0; wait_ticks(40);
        rxd = 1'b1; wait_ticks(4);
        rxd = 1'b0; wait_ticks(24);
        rxd = 1'b1; wait_ticks(20);
        send_char(8'hC3, 1'b0, 1'b0, 1'b1);
        rxd = 1'b1; wait_ticks(4);
        read_entry(e);
        chk("R6 break entry", e, {3'b110, 8'h00});
        read_entry(e);
        chk("R6 after rearm", e, {3'b000, 8'hC3});
        chk("R6 single slot", rx_ready, 0);

        // R7: break beginning mid-character
        send_bit(1'b0);
        rxd = 1'b1; wait_ticks(48);
        rxd = 1'b0; wait_ticks(18 * 16);
        rxd = 1'b1; wait_ticks(30);
        read_entry(e);
        chk("R7 cut character", e, {3'b010, 8'h07});
        read_entry(e);
        chk("R7 break entry", e, {3'b110, 8'h00});
        chk("R7 two entries only", rx_ready, 0);

        // R8: overrun
        for (int i = 0; i < 6; i++) begin
            send_char(8'(8'h10 + i), 1'b0, 1'b0, 1'b1);
            rxd = 1'b1; wait_ticks(4);
            if (i == 4) begin
                chk("R8 full at five", fifo_full, 1);
                chk("R8 no overrun at five", overrun, 0);
            end
        end
        chk("R8 overrun set", overrun, 1);
        chk("R8 still full", fifo_full, 1);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] d;
            d = (i < 4) ? 8'(8'h10 + i) : 8'h15;
            read_entry(e);
            chk("R8 survivor order", e, {3'b000, d});
        end
        chk("R8 drained", rx_ready, 0);
        chk("R9 sticky after reads", overrun, 1);

        // R11: receiver reset flushes store and waiting slot
        for (int i = 0; i < 5; i++) begin
            send_char(8'(8'h40 + i), 1'b0, 1'b0, 1'b1);
            rxd = 1'b1; wait_ticks(2);
        end
        chk("R11 loaded", rx_ready, 1);
        pulse(1);
        chk("R11 flushed", rx_ready, 0);
        chk("R9 survives rx reset", overrun, 1);
        wait_ticks(4);
        chk("R11 slot flushed", rx_ready, 0);
        send_char(8'h55, 1'b0, 1'b0, 1'b1);
        rxd = 1'b1; wait_ticks(4);
        read_entry(e);
        chk("R11 receive after reset", e, {3'b000, 8'h55});
        chk("R11 nothing stale", rx_ready, 0);

        // R9: clear command
        pulse(0);
        chk("R9 cleared", overrun, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule